// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupt Detection

The controller serves 96 general-purpose pins arranged as three banks of 32. A processor reaches it through a plain 32-bit register port: one select, one write strobe, a byte address and write data, with read data returned combinationally for whatever address is presented. For each bank, software can set the direction of each pin, load output data directly or change single bits through separate set and clear registers, and choose a polarity that inverts what the block sees on an input.

Each pin can raise an event on a rising edge, a falling edge, a high level or a low level. These four conditions have independent enable masks, so any mix of them is allowed. Events are latched in a per-pin pending register that software clears by writing ones. A companion register marks which pending bits were caused by an edge. Every bank feeds one shared interrupt output. Pin inputs pass through a two-flop synchroniser before they are used.

Address decode is fixed. Bits [7:4] pick a register group and bits [3:2] pick the bank. Each bank's copy of a group therefore sits at the group base plus four times the bank number.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, pin_oe and pin_out are all 0 and irq is 0.
- R2: A register is addressed as group base plus 4*bank, with the group in bus_addr[7:4] and the bank in bus_addr[3:2]. The group bases are: direction 0x00, polarity 0x10, data 0x20, data-set 0x30, data-clear 0x40, rising enable 0x50, falling enable 0x60, high-level enable 0x70, low-level enable 0x80, pending 0x90 and edge-origin 0xA0. A bank field of 3, or a group code above 0xA, reads 0, and writes to it change nothing.
- R3: Writing the data group loads the output latch of that bank. A 1 in a data-set write drives that pin_out bit high. A 1 in a data-clear write drives it low. Zero bits in either write leave the bit unchanged. pin_out changes only on a bus write.
- R4: A direction bit of 1 makes the pin an output, and pin_oe follows that bit. A read of the data group returns the output latch for output pins. For input pins it returns the synchronised input, which appears on the read on the second clock edge after pin_in changes.
- R5: A polarity bit of 1 inverts the synchronised input before both the data read and event detection.
- R6: For a pin whose rising (or falling) enable is set, a 0-to-1 (or 1-to-0) change of the seen input sets its pending bit once, on the third clock edge after pin_in changes. With both enables set, either edge sets the bit.
- R7: For a pin whose high-level (or low-level) enable is set, the pending bit is set on every cycle in which the seen input is 1 (or 0). Clearing the bit while the level holds therefore leaves it set.
- R8: Writing 1 to a pending bit clears it on that clock edge. Writing 0 has no effect. If an event for that bit is detected in the same cycle as the clearing write, the bit stays set.
- R9: An edge-origin bit is set whenever its pending bit is set by an edge event. It is cleared by the same write-one that clears the pending bit, is never set without the pending bit, and cannot be written directly.
- R10: irq is 1 exactly when at least one pending bit in any bank is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | Access is a write when 1, a read when 0 |
| bus_addr | input | 8 | Byte address: group in [7:4], bank in [3:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | 96 | Pad input values, pin n at bit n |
| pin_out | output | 96 | Output latch values |
| pin_oe | output | 96 | Output enables (direction bits) |
| irq | output | 1 | Shared interrupt, high while anything is pending |

## Verification
The hardest case to produce is a clearing write that lands in the exact cycle an edge event for the same bit is being detected. That event sits two synchroniser stages and one history register behind the pin. The stimulus first leaves a bit pending from an earlier edge. It then toggles the pin and issues the write-one so that the write is sampled on the third edge after the toggle, and the bit must stay set. Level events held across a clearing write cover the same rule over many cycles, and a behavioural reference model checks the read data, pins and interrupt on every clock.

// File: rtl/gpio_pkg.sv
// Package: shared constants and register-group codes of the banked GPIO controller.
// Assumes a byte address whose upper nibble selects the group.
package gpio_pkg;

    localparam int GRP_CNT = 11;

    typedef enum logic [3:0] {
        GRP_DIR  = 4'h0,
        GRP_POL  = 4'h1,
        GRP_DATA = 4'h2,
        GRP_DSET = 4'h3,
        GRP_DCLR = 4'h4,
        GRP_REN  = 4'h5,
        GRP_FEN  = 4'h6,
        GRP_HEN  = 4'h7,
        GRP_LEN  = 4'h8,
        GRP_STAT = 4'h9,
        GRP_EDGE = 4'hA
    } grp_e;

endpackage

// File: rtl/gpio_sync.sv
// Module: two-flop synchroniser for a vector of asynchronous pad inputs.
// Assumes each bit is independent. No bus coherence across bits is implied.
module gpio_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Two register stages, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= d_async;
            stage2_q <= stage1_q;
        end
    end

    assign d_sync = stage2_q;

endmodule

// File: rtl/gpio_event_detect.sv
// Module: per-pin edge and level event detector for one bank.
// Assumes 'seen' is already synchronised and polarity-adjusted. An edge is a
// difference between 'seen' and its value one cycle earlier.
module gpio_event_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] seen,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] high_en,
    input  logic [W-1:0] low_en,
    output logic [W-1:0] evt_edge,
    output logic [W-1:0] evt_level
);
    logic [W-1:0] hist_q;

    // History of the seen input, one cycle behind.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= seen;
    end

    // Per-bit event terms, one generate slice per pin.
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic went_up;
        logic went_down;
        always_comb begin
            went_up      = seen[i] & ~hist_q[i];
            went_down    = ~seen[i] & hist_q[i];
            evt_edge[i]  = (went_up & rise_en[i]) | (went_down & fall_en[i]);
            evt_level[i] = (seen[i] & high_en[i]) | (~seen[i] & low_en[i]);
        end
    end

endmodule

// File: rtl/gpio_bank.sv
// Module: one GPIO bank holding direction, polarity, output latch, four event
// enables, pending and edge-origin registers.
// Assumes at most one group write strobe is active per cycle (one bus port).
module gpio_bank
    import gpio_pkg::*;
#(
    parameter int W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [GRP_CNT-1:0] grp_wr,
    input  logic [W-1:0]       wdata,
    input  logic [W-1:0]       pad_in,
    output logic [W-1:0]       dir_q,
    output logic [W-1:0]       pol_q,
    output logic [W-1:0]       out_q,
    output logic [W-1:0]       ren_q,
    output logic [W-1:0]       fen_q,
    output logic [W-1:0]       hen_q,
    output logic [W-1:0]       len_q,
    output logic [W-1:0]       stat_q,
    output logic [W-1:0]       edge_q,
    output logic [W-1:0]       data_view,
    output logic [W-1:0]       evt_any,
    output logic [W-1:0]       clr_mask
);
    logic [W-1:0] pad_sync;
    logic [W-1:0] seen;
    logic [W-1:0] evt_edge;
    logic [W-1:0] evt_level;

    gpio_sync #(.W(W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pad_in),
        .d_sync  (pad_sync)
    );

    // Polarity-adjusted input as seen by reads and detection.
    assign seen = pad_sync ^ pol_q;

    gpio_event_detect #(.W(W)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .seen      (seen),
        .rise_en   (ren_q),
        .fall_en   (fen_q),
        .high_en   (hen_q),
        .low_en    (len_q),
        .evt_edge  (evt_edge),
        .evt_level (evt_level)
    );

    // Combine event kinds and form the write-one clear mask.
    always_comb begin
        evt_any  = evt_edge | evt_level;
        clr_mask = grp_wr[GRP_STAT] ? wdata : '0;
    end

    // Pin value read-back: latch for outputs, seen input for inputs.
    assign data_view = (dir_q & out_q) | (~dir_q & seen);

    // Configuration registers written whole by the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '0;
            pol_q <= '0;
            ren_q <= '0;
            fen_q <= '0;
            hen_q <= '0;
            len_q <= '0;
        end else begin
            if (grp_wr[GRP_DIR]) dir_q <= wdata;
            if (grp_wr[GRP_POL]) pol_q <= wdata;
            if (grp_wr[GRP_REN]) ren_q <= wdata;
            if (grp_wr[GRP_FEN]) fen_q <= wdata;
            if (grp_wr[GRP_HEN]) hen_q <= wdata;
            if (grp_wr[GRP_LEN]) len_q <= wdata;
        end
    end

    // Output latch: direct load, bit set or bit clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                out_q <= '0;
        else if (grp_wr[GRP_DATA]) out_q <= wdata;
        else if (grp_wr[GRP_DSET]) out_q <= out_q | wdata;
        else if (grp_wr[GRP_DCLR]) out_q <= out_q & ~wdata;
    end

    // Pending and edge-origin: write-one clear, a new event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            edge_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_mask) | evt_any;
            edge_q <= (edge_q & ~clr_mask) | evt_edge;
        end
    end

endmodule

// File: rtl/gpio_bank_ctrl.sv
// Module: top of the banked GPIO controller. Decodes the register port into
// per-bank group strobes, multiplexes read data, and ORs all pending bits into
// one interrupt.
// Assumes NUM_BANKS <= 4, since the bank field is bus_addr[3:2].
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int BANK_W    = 32,
    parameter int ADDR_W    = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [BANK_W-1:0]           bus_wdata,
    output logic [BANK_W-1:0]           bus_rdata,
    input  logic [NUM_BANKS*BANK_W-1:0] pin_in,
    output logic [NUM_BANKS*BANK_W-1:0] pin_out,
    output logic [NUM_BANKS*BANK_W-1:0] pin_oe,
    output logic                        irq
);
    localparam int NPINS  = NUM_BANKS * BANK_W;
    localparam int BIDX_W = 2;

    logic [3:0]        grp_sel;
    logic [BIDX_W-1:0] bank_sel;
    logic              bank_ok;
    logic              wr_go;
    logic [GRP_CNT-1:0] grp_hot;

    logic [NPINS-1:0] status_all;
    logic [NPINS-1:0] edge_all;
    logic [NPINS-1:0] evt_all;
    logic [NPINS-1:0] clr_all;

    logic [BANK_W-1:0] rd_bank [NUM_BANKS];

    logic unused_addr;
    assign unused_addr = ^bus_addr[1:0] ^ ^bus_addr[ADDR_W-1:8];

    // Address fields and write qualifier.
    always_comb begin
        grp_sel  = bus_addr[7:4];
        bank_sel = bus_addr[3:2];
        bank_ok  = {30'd0, bank_sel} < NUM_BANKS;
        wr_go    = bus_sel && bus_wr && bank_ok;
    end

    // One-hot group strobe; unmapped groups produce no strobe.
    always_comb begin
        grp_hot = '0;
        for (int g = 0; g < GRP_CNT; g++) begin
            if ({28'd0, grp_sel} == g) grp_hot[g] = 1'b1;
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [GRP_CNT-1:0] bwr;
        logic [BANK_W-1:0]  dir_q, pol_q, out_q, ren_q, fen_q, hen_q, len_q;
        logic [BANK_W-1:0]  stat_q, edge_q, view, evt, clr;

        // Strobes for this bank only.
        assign bwr = (wr_go && bank_sel == BIDX_W'(b)) ? grp_hot : '0;

        gpio_bank #(.W(BANK_W)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .grp_wr    (bwr),
            .wdata     (bus_wdata),
            .pad_in    (pin_in[b*BANK_W +: BANK_W]),
            .dir_q     (dir_q),
            .pol_q     (pol_q),
            .out_q     (out_q),
            .ren_q     (ren_q),
            .fen_q     (fen_q),
            .hen_q     (hen_q),
            .len_q     (len_q),
            .stat_q    (stat_q),
            .edge_q    (edge_q),
            .data_view (view),
            .evt_any   (evt),
            .clr_mask  (clr)
        );

        assign pin_out[b*BANK_W +: BANK_W]    = out_q;
        assign pin_oe[b*BANK_W +: BANK_W]     = dir_q;
        assign status_all[b*BANK_W +: BANK_W] = stat_q;
        assign edge_all[b*BANK_W +: BANK_W]   = edge_q;
        assign evt_all[b*BANK_W +: BANK_W]    = evt;
        assign clr_all[b*BANK_W +: BANK_W]    = clr;

        // Per-bank read selection by group.
        always_comb begin
            case (grp_sel)
                GRP_DIR:  rd_bank[b] = dir_q;
                GRP_POL:  rd_bank[b] = pol_q;
                GRP_DATA: rd_bank[b] = view;
                GRP_DSET: rd_bank[b] = out_q;
                GRP_DCLR: rd_bank[b] = out_q;
                GRP_REN:  rd_bank[b] = ren_q;
                GRP_FEN:  rd_bank[b] = fen_q;
                GRP_HEN:  rd_bank[b] = hen_q;
                GRP_LEN:  rd_bank[b] = len_q;
                GRP_STAT: rd_bank[b] = stat_q;
                GRP_EDGE: rd_bank[b] = edge_q;
                default:  rd_bank[b] = '0;
            endcase
        end
    end

    // Bank selection of read data; an absent bank reads zero.
    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_sel == BIDX_W'(b)) bus_rdata = rd_bank[b];
        end
    end

    // Shared interrupt from every pending bit.
    assign irq = |status_all;

endmodule

// File: rtl/gpio_ctrl_checker.sv
// Module: assertion checker for gpio_bank_ctrl, attached by bind.
// Assumes the top exposes its flattened pending, edge-origin, event and clear
// vectors.
module gpio_ctrl_checker #(
    parameter int NPINS = 96
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] pin_oe,
    input logic             irq,
    input logic [NPINS-1:0] status_all,
    input logic [NPINS-1:0] edge_all,
    input logic [NPINS-1:0] evt_all,
    input logic [NPINS-1:0] clr_all
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && !irq));

    // R3
    pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> ($stable(pin_out) && $stable(pin_oe)));

    // R6
    event_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_all != '0) |=> ((status_all & $past(evt_all)) == $past(evt_all)));

    // R8
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_all & ~evt_all) != '0) |=> ((status_all & $past(clr_all & ~evt_all)) == '0));

    // R9
    edge_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_all & ~status_all) == '0);

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(evt_all != '0));

endmodule

bind gpio_bank_ctrl gpio_ctrl_checker #(.NPINS(NUM_BANKS * BANK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .irq        (irq),
    .status_all (status_all),
    .edge_all   (edge_all),
    .evt_all    (evt_all),
    .clr_all    (clr_all)
);

// File: tb/gpio_bank_ctrl_tb.sv
// Bench: behavioural reference model compared every clock, plus directed reads.
module gpio_bank_ctrl_tb;
    localparam int NB = 3;
    localparam int BW = 32;
    localparam int NP = NB * BW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    bit live = 1'b0;

    always #5 clk = ~clk;

    gpio_bank_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    // Reference model state, indexed [bank] with integers.
    logic [31:0] m_reg [11][NB];
    logic [31:0] m_s1 [NB];
    logic [31:0] m_s2 [NB];
    logic [31:0] m_prev [NB];

    task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_view(input int b);
        logic [31:0] s;
        s = m_s2[b] ^ m_reg[1][b];
        return (m_reg[0][b] & m_reg[2][b]) | (~m_reg[0][b] & s);
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        int g;
        int b;
        g = int'(a[7:4]);
        b = int'(a[3:2]);
        if (b >= NB || g > 10) return 32'd0;
        if (g == 2) return m_view(b);
        if (g == 3 || g == 4) return m_reg[2][b];
        return m_reg[g][b];
    endfunction

    // Model step on each rising edge using inputs held since the last edge.
    always @(posedge clk) begin
        live <= 1'b1;
        for (int b = 0; b < NB; b++) begin
            logic [31:0] s, up, dn, ed, lv, clr;
            if (!rst_n) begin
                for (int g = 0; g < 11; g++) m_reg[g][b] = '0;
                m_s1[b] = '0; m_s2[b] = '0; m_prev[b] = '0;
            end else begin
                s   = m_s2[b] ^ m_reg[1][b];
                up  = s & ~m_prev[b];
                dn  = ~s & m_prev[b];
                ed  = (up & m_reg[5][b]) | (dn & m_reg[6][b]);
                lv  = (s & m_reg[7][b]) | (~s & m_reg[8][b]);
                clr = '0;
                if (bus_sel && bus_wr && int'(bus_addr[3:2]) == b) begin
                    case (int'(bus_addr[7:4]))
                        0, 1, 2, 5, 6, 7, 8: m_reg[int'(bus_addr[7:4])][b] = bus_wdata;
                        3: m_reg[2][b] = m_reg[2][b] | bus_wdata;
                        4: m_reg[2][b] = m_reg[2][b] & ~bus_wdata;
                        9: clr = bus_wdata;
                        default: ;
                    endcase
                end
                m_reg[9][b]  = (m_reg[9][b] & ~clr) | ed | lv;
                m_reg[10][b] = (m_reg[10][b] & ~clr) | ed;
                m_prev[b] = s;
                m_s2[b] = m_s1[b];
                m_s1[b] = pin_in[b*BW +: BW];
            end
        end
    end

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (live && rst_n) begin
            logic [NP-1:0] e_out, e_oe;
            logic e_irq;
            e_irq = 1'b0;
            for (int b = 0; b < NB; b++) begin
                e_out[b*BW +: BW] = m_reg[2][b];
                e_oe[b*BW +: BW]  = m_reg[0][b];
                e_irq = e_irq | (m_reg[9][b] != 0);
            end
            chk("R2 model rdata", NP'(bus_rdata), NP'(m_read(bus_addr)));
            chk("R3 model pin_out", pin_out, e_out);
            chk("R4 model pin_oe", pin_oe, e_oe);
            chk("R10 model irq", NP'(irq), NP'(e_irq));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick(1);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        chk(tag, NP'(bus_rdata), NP'(exp));
        tick(1);
        bus_sel = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        rd("R1 dir bank0", 8'h00, 32'h0);
        rd("R1 status bank2", 8'h98, 32'h0);
        chk("R1 irq", NP'(irq), '0);
        chk("R1 pin_oe", pin_oe, '0);

        // R3 data load, set and clear in bank1
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h24, 32'h0);
        wr(8'h34, 32'h0000_000F);
        wr(8'h44, 32'h0000_0003);
        rd("R3 data bank1", 8'h24, 32'h0000_000C);
        chk("R3 pin_out bank1", NP'(pin_out[35:32]), NP'(4'hC));
        chk("R4 pin_oe bank1", NP'(pin_oe[63:32]), NP'(32'hFFFF_FFFF));

        // R2 absent bank and unmapped group
        wr(8'h0C, 32'h0000_FFFF);
        rd("R2 bank3 slot", 8'h0C, 32'h0);
        rd("R2 group B", 8'hB0, 32'h0);
        rd("R2 bank0 dir untouched", 8'h00, 32'h0);

        // R4 input read-back and R5 polarity on bank2 bit 6
        pin_in[70] = 1'b1;
        tick(3);
        rd("R4 input view", 8'h28, 32'h0000_0040);
        wr(8'h18, 32'h0000_0040);
        tick(3);
        rd("R5 inverted view", 8'h28, 32'h0);
        wr(8'h18, 32'h0);
        tick(3);
        rd("R5 restored view", 8'h28, 32'h0000_0040);

        // R6 rising edge on pin 0
        wr(8'h50, 32'h1);
        pin_in[0] = 1'b1;
        tick(3);
        rd("R6 rise pending", 8'h90, 32'h1);
        rd("R9 rise origin", 8'hA0, 32'h1);
        chk("R10 irq set", NP'(irq), NP'(1'b1));
        wr(8'h90, 32'h1);
        rd("R8 cleared", 8'h90, 32'h0);
        chk("R10 irq clear", NP'(irq), '0);
        pin_in[0] = 1'b0;
        tick(3);
        rd("R6 fall not enabled", 8'h90, 32'h0);

        // R6 any edge on pin 1
        wr(8'h50, 32'h3);
        wr(8'h60, 32'h2);
        pin_in[1] = 1'b1;
        tick(3);
        rd("R6 any-edge up", 8'h90, 32'h2);
        wr(8'h90, 32'h2);
        pin_in[1] = 1'b0;
        tick(3);
        rd("R6 any-edge down", 8'h90, 32'h2);

        // R8 clear lands in the event cycle: event wins
        pin_in[1] = 1'b1;
        tick(2);
        wr(8'h90, 32'h2);
        rd("R8 event wins", 8'h90, 32'h2);
        wr(8'h90, 32'h0);
        rd("R8 write zero no effect", 8'h90, 32'h2);
        wr(8'h90, 32'h2);
        rd("R8 clear after race", 8'h90, 32'h0);
        rd("R9 origin cleared", 8'hA0, 32'h0);

        // R7 high level on pin 2 persists through clear
        wr(8'h70, 32'h4);
        pin_in[2] = 1'b1;
        tick(3);
        rd("R7 high level pending", 8'h90, 32'h4);
        wr(8'h90, 32'h4);
        rd("R7 clear has no lasting effect", 8'h90, 32'h4);
        rd("R9 level not edge", 8'hA0, 32'h0);
        wr(8'h70, 32'h0);
        wr(8'h90, 32'h4);
        rd("R7 cleared once disabled", 8'h90, 32'h0);

        // R7 low level in bank1 bit 5
        wr(8'h84, 32'h20);
        tick(2);
        rd("R7 low level pending", 8'h94, 32'h20);
        chk("R10 irq from bank1", NP'(irq), NP'(1'b1));
        rd("R9 low level origin", 8'hA4, 32'h0);
        wr(8'h84, 32'h0);
        wr(8'h94, 32'h20);
        rd("R8 bank1 cleared", 8'h94, 32'h0);
        chk("R10 irq all clear", NP'(irq), '0);

        tick(4);
        finish_run();
    end

endmodule